// File: doc/BRIEF.md
# TDM Slave Frame Receiver

This block receives an eight-channel, 16-bit time-division-multiplexed audio stream as a bus slave. An external master drives both the bit clock and a frame-start strobe. The block runs entirely on that bit clock. The strobe alone marks where a frame begins. Each time it is seen, the internal bit position goes back to zero. The serial data line is then collected MSB first into 16-bit words, one per channel slot.

Completed words leave through a small queue on a valid/ready output, each with the index of its channel slot. The master may run its bit clock faster than the payload needs, so a frame can be followed by any number of spare clocks. The spacing between strobes can also drift by a clock or two. The receiver discards all spare clocks and realigns on every strobe. It raises an idle flag once the payload of a frame is complete. It raises a one-cycle error pulse when a strobe cuts a frame short.

Top module: `tdm_frame_rx`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, the block clears its state: after that edge `word_valid` is 0, `idle` is 1 and `runt_err` is 0.
- R2: `fs` and `sdata` are sampled on rising `clk` edges. On the edge where `fs` is 1, the bit position becomes 0, and `sdata` on that same edge is taken as bit 15 (MSB) of channel 0.
- R3: Each channel word is built MSB first from 16 consecutive sampled bits. Channel c takes frame bit positions 16c to 16c+15.
- R4: Words are delivered in arrival order with `word_chan` = 0 to 7, matching the slot each word was taken from.
- R5: `idle` goes to 0 after the edge that samples `fs` high. It stays 0 through the 128 payload bits. It goes to 1 after the edge that samples bit position 127. It then holds at 1 until the next `fs`.
- R6: Strobes may arrive 128, 207, 208 or 209 clocks apart in any sequence. Every complete frame still yields its 8 correct words.
- R7: Clocks sampled after bit position 127 and before the next `fs` produce no words, whatever `sdata` carries and however many there are.
- R8: If `fs` is sampled while fewer than 128 bits of the current frame have been taken, `runt_err` is 1 for exactly the following cycle. An `fs` that arrives while `idle` is 1, or the first `fs` after reset, gives no pulse.
- R9: When a frame is cut short, words already completed are delivered. The unfinished word is discarded, and the new frame's channel 0 starts cleanly.
- R10: While `word_valid` is 1 and `word_ready` is 0, `word_data` and `word_chan` hold steady. The queue holds 8 words. A completed word that finds the queue full is dropped, and the queued words are left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock from the external master |
| rst | input | 1 | Synchronous active-high reset |
| fs | input | 1 | Frame-start strobe, sampled on the rising edge |
| sdata | input | 1 | Serial audio data, MSB first |
| word_ready | input | 1 | Consumer accepts the presented word |
| word_valid | output | 1 | A received word is presented |
| word_data | output | 16 | Received channel word |
| word_chan | output | 3 | Slot index of the presented word |
| idle | output | 1 | Payload of the current frame is complete |
| runt_err | output | 1 | One-cycle pulse: frame cut short by a strobe |

## Verification
A bit counter that fails to restart on the strobe shows up within one word time, 16 clocks. In that case channel 0 comes out rotated or carries a wrong index, and `idle` rises at the wrong clock. If the counter does not saturate, spare clocks after the payload show up as extra words two clocks after the sixteenth spare bit. A wrong runt decision appears on `runt_err` in the cycle right after the strobe. Queue faults show up on the cycle `word_ready` is low, as a word changing or a dropped word overwriting the head.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int DEF_WORD_W = 16;
  localparam int DEF_CHANS  = 8;
  localparam int DEF_QDEPTH = 8;

  typedef enum logic [1:0] {
    FR_WAIT   = 2'd0,
    FR_ACTIVE = 2'd1,
    FR_DONE   = 2'd2
  } frame_state_e;
endpackage

// File: rtl/tdm_bit_counter.sv
module tdm_bit_counter #(
  parameter int WORD_W = 16,
  parameter int CHANS  = 8,
  localparam int FRAME_BITS = WORD_W * CHANS,
  localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fs,
  output logic [CNT_W-1:0] pos,
  output logic             active,
  output logic             idle,
  output logic             runt
);
  import tdm_rx_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  frame_state_e     state;

  // The count saturates at FRAME_BITS, which doubles as the idle marker.
  assign state  = fs ? FR_ACTIVE :
                  (cnt_q == CNT_W'(FRAME_BITS)) ? FR_DONE : FR_WAIT;
  assign active = (state != FR_DONE);
  assign pos    = fs ? '0 : cnt_q;
  assign idle   = (cnt_q == CNT_W'(FRAME_BITS));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_W'(FRAME_BITS);
      runt  <= 1'b0;
    end else begin
      runt <= fs && (cnt_q != CNT_W'(FRAME_BITS));
      case (state)
        FR_ACTIVE: cnt_q <= CNT_W'(1);
        FR_WAIT:   cnt_q <= cnt_q + CNT_W'(1);
        default:   cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/tdm_word_shifter.sv
module tdm_word_shifter #(
  parameter int WORD_W = 16,
  parameter int CHANS  = 8,
  localparam int FRAME_BITS = WORD_W * CHANS,
  localparam int CNT_W = $clog2(FRAME_BITS + 1),
  localparam int BIT_W = $clog2(WORD_W),
  localparam int CH_W  = $clog2(CHANS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic [CNT_W-1:0]  pos,
  input  logic              sdata,
  output logic              push,
  output logic [WORD_W-1:0] push_data,
  output logic [CH_W-1:0]   push_chan
);
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] shnext;
  logic              last_bit;

  assign shnext   = {shreg[WORD_W-2:0], sdata};
  assign last_bit = active && (pos[BIT_W-1:0] == BIT_W'(WORD_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      push      <= 1'b0;
      push_data <= '0;
      push_chan <= '0;
    end else begin
      push <= last_bit;
      if (active) shreg <= shnext;
      if (last_bit) begin
        push_data <= shnext;
        push_chan <= pos[BIT_W+CH_W-1:BIT_W];
      end
    end
  end
endmodule

// File: rtl/tdm_word_fifo.sv
module tdm_word_fifo #(
  parameter int W     = 19,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_ready,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;
  logic          do_wr, do_rd;

  assign do_wr    = wr_en && (count != (AW+1)'(DEPTH));
  assign do_rd    = rd_ready && (count != '0);
  assign rd_valid = (count != '0);
  assign rd_data  = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (do_rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      count <= count + (AW+1)'(do_wr) - (AW+1)'(do_rd);
    end
  end
endmodule

// File: rtl/tdm_frame_rx.sv
module tdm_frame_rx #(
  parameter int WORD_W = tdm_rx_pkg::DEF_WORD_W,
  parameter int CHANS  = tdm_rx_pkg::DEF_CHANS,
  parameter int QDEPTH = tdm_rx_pkg::DEF_QDEPTH,
  localparam int CH_W  = $clog2(CHANS),
  localparam int CNT_W = $clog2(WORD_W * CHANS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fs,
  input  logic              sdata,
  input  logic              word_ready,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic [CH_W-1:0]   word_chan,
  output logic              idle,
  output logic              runt_err
);
  logic [CNT_W-1:0]  pos;
  logic              active;
  logic              push;
  logic [WORD_W-1:0] push_data;
  logic [CH_W-1:0]   push_chan;

  tdm_bit_counter #(.WORD_W(WORD_W), .CHANS(CHANS)) cnt_i (
    .clk(clk), .rst(rst), .fs(fs), .pos(pos), .active(active),
    .idle(idle), .runt(runt_err)
  );

  tdm_word_shifter #(.WORD_W(WORD_W), .CHANS(CHANS)) shf_i (
    .clk(clk), .rst(rst), .active(active), .pos(pos), .sdata(sdata),
    .push(push), .push_data(push_data), .push_chan(push_chan)
  );

  tdm_word_fifo #(.W(WORD_W + CH_W), .DEPTH(QDEPTH)) q_i (
    .clk(clk), .rst(rst), .wr_en(push), .wr_data({push_chan, push_data}),
    .rd_ready(word_ready), .rd_valid(word_valid),
    .rd_data({word_chan, word_data})
  );
endmodule

// File: rtl/tdm_frame_rx_chk.sv
module tdm_frame_rx_chk #(
  parameter int WORD_W = 16,
  parameter int CH_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              fs,
  input logic              word_ready,
  input logic              word_valid,
  input logic [WORD_W-1:0] word_data,
  input logic [CH_W-1:0]   word_chan,
  input logic              idle,
  input logic              runt_err
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (idle && !word_valid && !runt_err));

  p_fs_clears_idle_r5: assert property (@(posedge clk) disable iff (rst)
    fs |=> !idle);

  p_runt_follows_fs_r8: assert property (@(posedge clk) disable iff (rst)
    runt_err |-> $past(fs));

  p_no_runt_from_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (fs && idle) |=> !runt_err);

  p_hold_when_stalled_r10: assert property (@(posedge clk) disable iff (rst)
    (word_valid && !word_ready) |=>
      (word_valid && $stable(word_data) && $stable(word_chan)));
endmodule

bind tdm_frame_rx tdm_frame_rx_chk #(.WORD_W(WORD_W), .CH_W(CH_W)) chk_i (
  .clk(clk), .rst(rst), .fs(fs), .word_ready(word_ready),
  .word_valid(word_valid), .word_data(word_data), .word_chan(word_chan),
  .idle(idle), .runt_err(runt_err)
);

// File: tb/tdm_frame_rx_tb_top.sv
module tdm_frame_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fs = 1'b0;
  logic        sdata = 1'b0;
  logic        word_ready = 1'b1;
  logic        word_valid;
  logic [15:0] word_data;
  logic [2:0]  word_chan;
  logic        idle;
  logic        runt_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] rx_d [0:255];
  logic [2:0]  rx_c [0:255];
  int          rx_n = 0;
  logic [15:0] exp_d [0:255];
  logic [2:0]  exp_c [0:255];
  int          exp_n = 0;

  always #4 clk = ~clk;

  tdm_frame_rx dut_i (
    .clk(clk), .rst(rst), .fs(fs), .sdata(sdata), .word_ready(word_ready),
    .word_valid(word_valid), .word_data(word_data), .word_chan(word_chan),
    .idle(idle), .runt_err(runt_err)
  );

  always @(negedge clk) begin
    if (!rst && word_valid && word_ready && rx_n < 256) begin
      rx_d[rx_n] = word_data;
      rx_c[rx_n] = word_chan;
      rx_n = rx_n + 1;
    end
  end

  function automatic logic [15:0] pat(input int f, input int c);
    return 16'((f * 8 + c) * 40503 + 16'h1234);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One frame: strobe, nact payload bits, then filler up to period clocks.
  task automatic send_frame(input int fid, input int period, input int nact,
                            input bit expect_words, input bit exp_runt);
    for (int i = 0; i < period; i++) begin
      @(negedge clk);
      if (i == 1) begin
        chk(runt_err == exp_runt, "R8", "runt after strobe", runt_err, exp_runt);
        chk(idle == 1'b0, "R5", "idle low after strobe", idle, 0);
      end
      if (i == 2) chk(runt_err == 1'b0, "R8", "runt one cycle", runt_err, 0);
      if (i == 127 && nact >= 128) chk(idle == 1'b0, "R5", "idle low before bit 127", idle, 0);
      if (i == 128 && nact >= 128) chk(idle == 1'b1, "R5", "idle high after payload", idle, 1);
      fs = (i == 0);
      if (i < nact && i < 128) sdata = pat(fid, i / 16)[15 - (i % 16)];
      else sdata = ((i * 5 + fid) % 3) == 0;
    end
    if (expect_words)
      for (int c = 0; c < 8; c++)
        if ((c + 1) * 16 <= nact) begin
          exp_d[exp_n] = pat(fid, c);
          exp_c[exp_n] = 3'(c);
          exp_n++;
        end
  endtask

  task automatic idle_clocks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fs = 1'b0;
      sdata = i[0];
    end
  endtask

  task automatic compare_words(input int rb, input int eb, input string req);
    chk((rx_n - rb) == (exp_n - eb), req, "word count", rx_n - rb, exp_n - eb);
    for (int k = 0; k < exp_n - eb && k < rx_n - rb; k++) begin
      chk(rx_d[rb + k] == exp_d[eb + k], req, "word data", rx_d[rb + k], exp_d[eb + k]);
      chk(rx_c[rb + k] == exp_c[eb + k], "R4", "channel index", rx_c[rb + k], exp_c[eb + k]);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(word_valid == 1'b0, "R1", "valid after reset", word_valid, 0);
    chk(idle == 1'b1, "R1", "idle after reset", idle, 1);
    chk(runt_err == 1'b0, "R1", "runt after reset", runt_err, 0);
  endtask

  // R2 R3 R4 R7: one frame with 80 spare clocks.
  task automatic t_single;
    int rb, eb;
    rb = rx_n; eb = exp_n;
    send_frame(1, 208, 128, 1'b1, 1'b0);
    idle_clocks(20);
    compare_words(rb, eb, "R2 R3 R7");
  endtask

  // R6: drifting strobe spacing, including no spare clocks at all.
  task automatic t_variable;
    int rb, eb;
    rb = rx_n; eb = exp_n;
    send_frame(2, 207, 128, 1'b1, 1'b0);
    send_frame(3, 209, 128, 1'b1, 1'b0);
    send_frame(4, 128, 128, 1'b1, 1'b0);
    send_frame(5, 208, 128, 1'b1, 1'b0);
    send_frame(6, 300, 128, 1'b1, 1'b0);
    idle_clocks(20);
    compare_words(rb, eb, "R6");
  endtask

  // R8 R9: frame cut at bit 40, then a full frame.
  task automatic t_runt;
    int rb, eb;
    rb = rx_n; eb = exp_n;
    send_frame(7, 40, 40, 1'b1, 1'b0);
    send_frame(8, 208, 128, 1'b1, 1'b1);
    idle_clocks(20);
    compare_words(rb, eb, "R9");
  endtask

  // R10: stall the consumer across two frames.
  task automatic t_backpressure;
    int rb, eb;
    rb = rx_n; eb = exp_n;
    word_ready = 1'b0;
    send_frame(20, 208, 128, 1'b0, 1'b0);
    send_frame(21, 208, 128, 1'b0, 1'b0);
    @(negedge clk);
    chk(word_valid == 1'b1, "R10", "valid held while stalled", word_valid, 1);
    chk(word_data == pat(20, 0), "R10", "head word held", word_data, pat(20, 0));
    chk(word_chan == 3'd0, "R10", "head chan held", word_chan, 0);
    for (int c = 0; c < 8; c++) begin
      exp_d[exp_n] = pat(20, c);
      exp_c[exp_n] = 3'(c);
      exp_n++;
    end
    word_ready = 1'b1;
    idle_clocks(30);
    compare_words(rb, eb, "R10");
    chk(word_valid == 1'b0, "R10", "queue empty after drain", word_valid, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_single();
    t_variable();
    t_runt();
    t_backpressure();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule